// File: doc/BRIEF.md
# Clock-Level-Gated 16x1 Static Memory Array

This block is a synthesizable behavioural model of a small static memory: sixteen one-bit cells laid out as a four-by-four grid, with the low address pair picking a row and the high address pair picking a column. An access-clock level input, sampled on the system clock, splits time into two phases. While it is high, the selected cell can be read or written. While it is low, the bit lines are equalised: no row or column is selected, nothing is stored, and the output holds its last value.

Read data does not show up at once. It is delivered a parameterised number of system-clock edges after the access clock is first seen high. The data-valid flag marks the cycles in which the output carries the addressed cell. The array is preloaded from a 16-bit parameter on reset, so a cell can return a known value before it is ever written.

Top module: `sram_cell_array16`

## Requirements
- R1: A synchronous active-low reset loads bit i of the INIT_BITS parameter into the cell at address i, clears dout to 0 and clears dvalid. The default INIT_BITS is 16'h4000, so only address 1110 holds 1.
- R2: addr[1:0] selects the row and addr[3:2] selects the column, and the cell index is column*4+row. For example, 0110 is row 2, column 1. Exactly one row and one column are selected while acc_clk is high.
- R3: While acc_clk is sampled low, no row or column is selected and nothing is written, whatever we and din are. On the next edge dvalid goes low, and dout keeps its previous value.
- R4: A rising clk edge with acc_clk and we both high stores din in the addressed cell. On the following cycle dvalid is low.
- R5: When acc_clk is high and we is low, the ACC_DLY-th consecutive such edge (default 1) loads dout with the addressed cell and raises dvalid. The earlier edges leave dvalid low.
- R6: A value written in one active phase is returned by a read of the same address in the next active phase.
- R7: A write to one address leaves the other fifteen cells unchanged.
- R8: This access sequence returns the values given: read 0000 gives 0; read 0001; write 1 to 0001; write 0 to 0100; read 0000 gives 0; read 1110 gives 1, twice; read 0100 gives 0; read 0001 gives 1; read 0000 gives 0, twice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_clk | input | 1 | Access-clock level: high = active phase, low = equalisation |
| addr | input | 4 | Cell address; [3:2] column, [1:0] row |
| we | input | 1 | Write enable, effective only in the active phase |
| din | input | 1 | Data bit to write |
| dout | output | 1 | Registered read data; held during equalisation |
| dvalid | output | 1 | High when dout carries the addressed cell after the access delay |

## Verification
The assertions assume that addr and we do not change within one active phase. Under that assumption, any output marked valid must have been preceded by a sampled read phase. The stimulus keeps to this: each access applies address, write enable and data together with the rising access level, and holds them until the access level falls. At least one equalisation cycle separates any two accesses. The bench sweeps every address over preload, pattern, complement and single-one backgrounds. It also drives writes during equalisation to show that they are ignored.

// File: rtl/sram16_pkg.sv
// Package: default geometry of the 16x1 cell grid.
// Assumes a square power-of-two grid; address = {column, row}.
package sram16_pkg;
    localparam int unsigned ROW_BITS_DEF = 2;
    localparam int unsigned COL_BITS_DEF = 2;
    localparam int unsigned ACC_DLY_DEF  = 1;
endpackage

// File: rtl/sram16_line_decoder.sv
// Line decoder: one-hot select of 2**W lines from a W-bit code,
// forced to all-zero while the enable (access level) is low.
// Assumes the code is stable while en is high.
module sram16_line_decoder #(
    parameter int unsigned W = 2,
    localparam int unsigned N = 1 << W
) (
    input  logic [W-1:0] code,
    input  logic         en,
    output logic [N-1:0] sel
);
    // One compare per line, each gated by the enable
    for (genvar i = 0; i < N; i++) begin : g_line
        assign sel[i] = en && (code == W'(i));
    end
endmodule

// File: rtl/sram16_cell_grid.sv
// Cell grid: ROWS x COLS one-bit storage cells. A cell is written when
// its row and column are both selected and wr_en is high; the read bit
// is the OR of all cells at a selected row/column crossing.
// Assumes at most one row and one column are selected at a time.
module sram16_cell_grid #(
    parameter int unsigned ROWS = 4,
    parameter int unsigned COLS = 4,
    localparam int unsigned N   = ROWS * COLS,
    parameter logic [N-1:0] INIT_BITS = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ROWS-1:0] row_sel,
    input  logic [COLS-1:0] col_sel,
    input  logic            wr_en,
    input  logic            din,
    output logic            rd_bit
);
    logic [N-1:0] cells;
    logic [N-1:0] hit;

    // Crossing of row and column selects, indexed column*ROWS+row
    for (genvar c = 0; c < COLS; c++) begin : g_col
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            assign hit[c*ROWS + r] = row_sel[r] && col_sel[c];
        end
    end

    // Cell storage: preload on reset, write the selected crossing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cells <= INIT_BITS;
        end else if (wr_en) begin
            for (int k = 0; k < int'(N); k++) begin
                if (hit[k]) cells[k] <= din;
            end
        end
    end

    // Read sensing: only the selected cell reaches the data line
    assign rd_bit = |(cells & hit);
endmodule

// File: rtl/sram16_read_timer.sv
// Read timer: counts consecutive read edges in an active phase and,
// on the ACC_DLY-th, latches the sensed bit and raises valid. Any
// equalisation or write edge restarts the count and drops valid;
// the latched data is held.
// Assumes addr/we are stable within one active phase.
module sram16_read_timer #(
    parameter int unsigned ACC_DLY = 1,
    localparam int unsigned CNT_W  = $clog2(ACC_DLY + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic acc_clk,
    input  logic we,
    input  logic rd_bit,
    output logic dout,
    output logic dvalid
);
    logic [CNT_W-1:0] cnt;

    // Access-delay counter and output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            dout   <= 1'b0;
            dvalid <= 1'b0;
        end else if (!acc_clk || we) begin
            cnt    <= '0;
            dvalid <= 1'b0;
        end else if (cnt >= CNT_W'(ACC_DLY - 1)) begin
            dout   <= rd_bit;
            dvalid <= 1'b1;
        end else begin
            cnt    <= cnt + 1'b1;
            dvalid <= 1'b0;
        end
    end
endmodule

// File: rtl/sram_cell_array16.sv
// Top: 16x1 static memory with row/column decoding gated by the
// access-clock level. High level = access, low level = equalisation.
// Assumes acc_clk, addr, we and din are synchronous to clk.
module sram_cell_array16 #(
    parameter int unsigned ROW_BITS = sram16_pkg::ROW_BITS_DEF,
    parameter int unsigned COL_BITS = sram16_pkg::COL_BITS_DEF,
    parameter int unsigned ACC_DLY  = sram16_pkg::ACC_DLY_DEF,
    localparam int unsigned ROWS    = 1 << ROW_BITS,
    localparam int unsigned COLS    = 1 << COL_BITS,
    localparam int unsigned AW      = ROW_BITS + COL_BITS,
    parameter logic [ROWS*COLS-1:0] INIT_BITS = 16'h4000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_clk,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic          din,
    output logic          dout,
    output logic          dvalid
);
    logic [ROWS-1:0] row_sel;
    logic [COLS-1:0] col_sel;
    logic            rd_bit;
    logic            wr_en;

    // Write path enabled only in the active phase
    assign wr_en = acc_clk && we;

    sram16_line_decoder #(.W(ROW_BITS)) u_row_dec (
        .code (addr[ROW_BITS-1:0]),
        .en   (acc_clk),
        .sel  (row_sel)
    );

    sram16_line_decoder #(.W(COL_BITS)) u_col_dec (
        .code (addr[AW-1:ROW_BITS]),
        .en   (acc_clk),
        .sel  (col_sel)
    );

    sram16_cell_grid #(.ROWS(ROWS), .COLS(COLS), .INIT_BITS(INIT_BITS)) u_grid (
        .clk     (clk),
        .rst_n   (rst_n),
        .row_sel (row_sel),
        .col_sel (col_sel),
        .wr_en   (wr_en),
        .din     (din),
        .rd_bit  (rd_bit)
    );

    sram16_read_timer #(.ACC_DLY(ACC_DLY)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_clk (acc_clk),
        .we      (we),
        .rd_bit  (rd_bit),
        .dout    (dout),
        .dvalid  (dvalid)
    );
endmodule

// File: rtl/sram16_checker.sv
// Checker: phase and select properties of sram_cell_array16.
// Assumes addr/we stable within an active phase (see brief).
module sram16_checker #(
    parameter int unsigned ROW_BITS = 2,
    parameter int unsigned COL_BITS = 2,
    parameter int unsigned ACC_DLY  = 1,
    localparam int unsigned ROWS    = 1 << ROW_BITS,
    localparam int unsigned COLS    = 1 << COL_BITS
) (
    input logic            clk,
    input logic            rst_n,
    input logic            acc_clk,
    input logic            we,
    input logic            dout,
    input logic            dvalid,
    input logic [ROWS-1:0] row_sel,
    input logic [COLS-1:0] col_sel
);
    // R3: equalisation selects nothing
    p_no_select_eq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_clk |-> (row_sel == '0) && (col_sel == '0));

    // R2: active phase selects exactly one row and one column
    p_onehot_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_clk |-> ($countones(row_sel) == 1) && ($countones(col_sel) == 1));

    // R3: equalisation drops valid on the next edge
    p_valid_drop_eq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_clk |=> !dvalid);

    // R3: equalisation holds the output bit
    p_dout_hold_eq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_clk |=> $stable(dout));

    // R4: a write edge is never followed by valid
    p_no_valid_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_clk && we) |=> !dvalid);

    // R5: valid only follows a sampled read edge
    p_valid_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dvalid |-> ($past(acc_clk) && !$past(we)));
endmodule

bind sram_cell_array16 sram16_checker #(
    .ROW_BITS (ROW_BITS),
    .COL_BITS (COL_BITS),
    .ACC_DLY  (ACC_DLY)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc_clk (acc_clk),
    .we      (we),
    .dout    (dout),
    .dvalid  (dvalid),
    .row_sel (row_sel),
    .col_sel (col_sel)
);

// File: tb/test_sram_cell_array16.sv
// Bench: sweeps every address over several backgrounds, replays the
// fixed access sequence and checks equalisation behaviour.
module test_sram_cell_array16;
    localparam int unsigned DLY  = 1;
    localparam logic [15:0] INIT = 16'h4000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_clk = 1'b0;
    logic [3:0] addr = '0;
    logic       we = 1'b0;
    logic       din = 1'b0;
    logic       dout;
    logic       dvalid;

    int   total = 0;
    int   bad = 0;
    logic [15:0] model;
    logic rv;

    always #5 clk = ~clk;

    sram_cell_array16 #(.ACC_DLY(DLY), .INIT_BITS(INIT)) i_sram_cell_array16 (
        .clk(clk), .rst_n(rst_n), .acc_clk(acc_clk), .addr(addr),
        .we(we), .din(din), .dout(dout), .dvalid(dvalid)
    );

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Read one address; checks valid timing and the hold afterwards
    task automatic do_read(input logic [3:0] a, input string req, output logic val);
        @(negedge clk);
        acc_clk = 1'b1; addr = a; we = 1'b0;
        repeat (DLY) @(negedge clk);
        val = dout;
        check("R5 valid", dvalid, 1'b1);
        check(req, dout, model[a]);
        acc_clk = 1'b0;
        @(negedge clk);
        check("R3 valid low", dvalid, 1'b0);
        check("R3 hold", dout, val);
    endtask

    task automatic do_write(input logic [3:0] a, input logic d);
        @(negedge clk);
        acc_clk = 1'b1; addr = a; we = 1'b1; din = d;
        @(negedge clk);
        check("R4 no valid", dvalid, 1'b0);
        model[a] = d;
        acc_clk = 1'b0; we = 1'b0;
    endtask

    task automatic read_all(input string req);
        for (int a = 0; a < 16; a++) do_read(4'(a), req, rv);
    endtask

    initial begin
        model = INIT;
        repeat (3) @(negedge clk);
        check("R1 dout reset", dout, 1'b0);
        check("R1 dvalid reset", dvalid, 1'b0);
        rst_n = 1'b1;
        read_all("R1 preload");

        // R8: fixed sequence
        do_read(4'b0000, "R8 seq", rv); check("R8 0000", rv, 1'b0);
        do_read(4'b0001, "R8 seq", rv);
        do_write(4'b0001, 1'b1);
        do_write(4'b0100, 1'b0);
        do_read(4'b0000, "R8 seq", rv); check("R8 0000", rv, 1'b0);
        do_read(4'b1110, "R8 seq", rv); check("R8 1110", rv, 1'b1);
        do_read(4'b1110, "R8 seq", rv); check("R8 1110", rv, 1'b1);
        do_read(4'b0100, "R8 seq", rv); check("R8 0100", rv, 1'b0);
        do_read(4'b0001, "R8 seq", rv); check("R6 R8 0001", rv, 1'b1);
        do_read(4'b0000, "R8 seq", rv); check("R8 0000", rv, 1'b0);
        do_read(4'b0000, "R8 seq", rv); check("R8 0000", rv, 1'b0);

        // R6: arithmetic pattern then its complement
        for (int a = 0; a < 16; a++) do_write(4'(a), ^(4'(a) ^ 4'(a >> 1)));
        read_all("R6 pattern");
        for (int a = 0; a < 16; a++) do_write(4'(a), ~model[a]);
        read_all("R6 complement");

        // R7/R2: single one walking over a zero background, incl. 0110
        for (int a = 0; a < 16; a++) do_write(4'(a), 1'b0);
        for (int s = 0; s < 16; s++) begin
            do_write(4'(s), 1'b1);
            read_all(s == 6 ? "R2 R7 map 0110" : "R7 isolation");
            do_write(4'(s), 1'b0);
        end

        // R3: writes attempted during equalisation are ignored
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            acc_clk = 1'b0; addr = 4'(a); we = 1'b1; din = 1'b1;
            @(negedge clk);
            check("R3 eq write valid", dvalid, 1'b0);
            we = 1'b0; din = 1'b0;
        end
        read_all("R3 eq write ignored");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule